// File: doc/BRIEF.md
# External and Pin-Change Interrupt Unit

This block turns pin activity into interrupt requests for a small microcontroller. One dedicated request pin, `int0_pin`, has a selectable sense: low level, any change, falling edge or rising edge. Twelve general pins `pc_pins[11:0]` form two pin-change groups. The lower eight pins feed group 0 and the upper four feed group 1. Each pin has its own mask bit, and any enabled pin that toggles raises its group's request. Detection uses the pin level only, so a pin that the core drives as an output still triggers its interrupt. Software can use this to raise an interrupt on purpose.

Each edge-type source keeps a sticky pending flag. A flag clears through a clear strobe or an acknowledge. Each request output is its flag gated by the source's enable. The low-level request has no flag and follows the pin for as long as it stays low.

Edge detection on `int0_pin` needs the I/O clock, which is signalled by `io_clk_run`. The low-level sense and the pin-change toggles also drive a combinational `wake` output, which works while that clock is stopped.

Top module: `ext_irq_unit`

## Requirements
- R1: A synchronous reset clears all three flags and all three request outputs. The synchroniser stages load the current pin levels during reset, so pins held steady across reset cause no event.
- R2: A toggle in either direction on any of `pc_pins[7:0]` whose `mask_g0` bit is 1 sets `pcg0_flag`. A toggle on a pin whose mask bit is 0 leaves the flag unchanged.
- R3: A toggle on any of `pc_pins[11:8]` whose `mask_g1` bit is 1 sets `pcg1_flag`. Bit i of `mask_g1` belongs to pin 8+i. A toggle on a pin whose mask bit is 0 is ignored.
- R4: Each request output is registered and equals its flag ANDed with its enable, with one cycle of delay from the enable. A flag sets even while its enable is 0, and its request appears one clock after the enable is set.
- R5: `flag_clr[k]` or `irq_ack[k]` clears flag k, where bit 0 is INT0, bit 1 is group 0 and bit 2 is group 1. A new event in the same cycle wins over the clear.
- R6: With `int0_sense` = 2'b10, a falling edge on `int0_pin` sets `int0_flag`, and a rising edge does not.
- R7: With `int0_sense` = 2'b11, a rising edge on `int0_pin` sets `int0_flag`, and a falling edge does not.
- R8: With `int0_sense` = 2'b01, edges of either direction on `int0_pin` set `int0_flag`.
- R9: With `int0_sense` = 2'b00 and `int0_en` = 1, `int0_req` stays high for as long as `int0_pin` is low, and it never sets `int0_flag`.
- R10: Edges on `int0_pin` are not recognised while `io_clk_run` is 0.
- R11: `wake` is combinational. It is high while the enabled low-level sense sees `int0_pin` low. It is also high while an enabled, unmasked pin-change pin differs from a reference that stops updating while `io_clk_run` is 0 and that follows the pins otherwise.
- R12: A pin change sets its flag on the third rising clock edge after the change. The flag is still clear after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int0_pin | input | 1 | Dedicated interrupt pin level |
| int0_sense | input | 2 | 00 low, 01 any change, 10 falling, 11 rising |
| int0_en | input | 1 | INT0 enable |
| pc_pins | input | 12 | Pin-change pin levels |
| mask_g0 | input | 8 | Per-pin enables for pins 7..0 |
| mask_g1 | input | 4 | Per-pin enables for pins 11..8 |
| pcg0_en | input | 1 | Group 0 enable |
| pcg1_en | input | 1 | Group 1 enable |
| flag_clr | input | 3 | Flag clear strobes {g1, g0, int0} |
| irq_ack | input | 3 | Acknowledge strobes {g1, g0, int0} |
| io_clk_run | input | 1 | High while the I/O clock runs |
| int0_flag | output | 1 | INT0 pending flag |
| pcg0_flag | output | 1 | Group 0 pending flag |
| pcg1_flag | output | 1 | Group 1 pending flag |
| int0_req | output | 1 | INT0 request |
| pcg0_req | output | 1 | Group 0 request |
| pcg1_req | output | 1 | Group 1 request |
| wake | output | 1 | Asynchronous wake request |

## Verification
The hardest condition to reach is a clear strobe that lands in the same cycle as a new event. The bench must drive the pin change exactly two clock edges before the clear edge, so that the synchronised toggle and the strobe meet. A second hard case is the wake path while the I/O clock is stopped. Here the reference must be frozen first, and then a masked toggle and an unmasked toggle are applied in turn and `wake` is sampled combinationally before the clock-run indicator returns.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

  localparam int SRC_INT0 = 0;
  localparam int SRC_G0   = 1;
  localparam int SRC_G1   = 2;
  localparam int NSRC     = 3;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] s1;

  // reset loads live levels so steady pins produce no event after reset
  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= d;
      cur  <= d;
      prev <= d;
    end else begin
      s1   <= d;
      cur  <= s1;
      prev <= cur;
    end
  end
endmodule

// File: rtl/ext_irq_pcgroup.sv
module ext_irq_pcgroup #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         io_run,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] mask,
  input  logic         en,
  output logic         hit,
  output logic         wake
);
  logic [W-1:0] snap;

  always_ff @(posedge clk) begin
    if (rst)         snap <= raw;
    else if (io_run) snap <= raw;
  end

  // flag may set with the group disabled; wake only when enabled
  assign hit  = |((cur ^ prev) & mask);
  assign wake = en & (|((raw ^ snap) & mask));
endmodule

// File: rtl/ext_irq_int0.sv
module ext_irq_int0
  import ext_irq_pkg::*;
(
  input  logic       raw,
  input  logic       cur,
  input  logic       prev,
  input  logic [1:0] sense,
  input  logic       en,
  input  logic       io_run,
  output logic       hit,
  output logic       lvl,
  output logic       wake
);
  logic rise, fall, is_low;

  assign rise   = cur & ~prev;
  assign fall   = ~cur & prev;
  assign is_low = (sense_e'(sense) == SNS_LOW);

  always_comb begin
    unique case (sense_e'(sense))
      SNS_ANY:  hit = rise | fall;
      SNS_FALL: hit = fall;
      SNS_RISE: hit = rise;
      default:  hit = 1'b0;
    endcase
    hit = hit & io_run;
  end

  assign lvl  = en & is_low & ~cur;
  assign wake = en & is_low & ~raw;
endmodule

// File: rtl/ext_irq_flag.sv
module ext_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag,
  output logic flag_nx
);
  // a new event outranks a clear in the same cycle
  assign flag_nx = set | (flag & ~clr);

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= flag_nx;
  end
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
  import ext_irq_pkg::*;
#(
  parameter int G0_W = 8,
  parameter int G1_W = 4,
  localparam int NPIN = G0_W + G1_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            int0_pin,
  input  logic [1:0]      int0_sense,
  input  logic            int0_en,
  input  logic [NPIN-1:0] pc_pins,
  input  logic [G0_W-1:0] mask_g0,
  input  logic [G1_W-1:0] mask_g1,
  input  logic            pcg0_en,
  input  logic            pcg1_en,
  input  logic [2:0]      flag_clr,
  input  logic [2:0]      irq_ack,
  input  logic            io_clk_run,
  output logic            int0_flag,
  output logic            pcg0_flag,
  output logic            pcg1_flag,
  output logic            int0_req,
  output logic            pcg0_req,
  output logic            pcg1_req,
  output logic            wake
);
  logic [NPIN-1:0] pc_cur, pc_prev;
  logic            i0_cur, i0_prev;
  logic [NSRC-1:0] src_set, src_flag, src_nx, src_en;
  logic            i0_lvl, i0_wake, g0_wake, g1_wake;

  ext_irq_sync #(.W(NPIN)) u_pc_sync (
    .clk(clk), .rst(rst), .d(pc_pins), .cur(pc_cur), .prev(pc_prev)
  );

  ext_irq_sync #(.W(1)) u_i0_sync (
    .clk(clk), .rst(rst), .d(int0_pin), .cur(i0_cur), .prev(i0_prev)
  );

  ext_irq_int0 u_i0 (
    .raw(int0_pin), .cur(i0_cur), .prev(i0_prev), .sense(int0_sense),
    .en(int0_en), .io_run(io_clk_run),
    .hit(src_set[SRC_INT0]), .lvl(i0_lvl), .wake(i0_wake)
  );

  ext_irq_pcgroup #(.W(G0_W)) u_g0 (
    .clk(clk), .rst(rst), .io_run(io_clk_run),
    .raw(pc_pins[G0_W-1:0]), .cur(pc_cur[G0_W-1:0]), .prev(pc_prev[G0_W-1:0]),
    .mask(mask_g0), .en(pcg0_en), .hit(src_set[SRC_G0]), .wake(g0_wake)
  );

  ext_irq_pcgroup #(.W(G1_W)) u_g1 (
    .clk(clk), .rst(rst), .io_run(io_clk_run),
    .raw(pc_pins[NPIN-1:G0_W]), .cur(pc_cur[NPIN-1:G0_W]), .prev(pc_prev[NPIN-1:G0_W]),
    .mask(mask_g1), .en(pcg1_en), .hit(src_set[SRC_G1]), .wake(g1_wake)
  );

  assign src_en = {pcg1_en, pcg0_en, int0_en};

  for (genvar k = 0; k < NSRC; k++) begin : g_flag
    ext_irq_flag u_flag (
      .clk(clk), .rst(rst), .set(src_set[k]), .clr(flag_clr[k] | irq_ack[k]),
      .flag(src_flag[k]), .flag_nx(src_nx[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int0_req <= 1'b0;
      pcg0_req <= 1'b0;
      pcg1_req <= 1'b0;
    end else begin
      int0_req <= (src_nx[SRC_INT0] & src_en[SRC_INT0]) | i0_lvl;
      pcg0_req <= src_nx[SRC_G0] & src_en[SRC_G0];
      pcg1_req <= src_nx[SRC_G1] & src_en[SRC_G1];
    end
  end

  assign int0_flag = src_flag[SRC_INT0];
  assign pcg0_flag = src_flag[SRC_G0];
  assign pcg1_flag = src_flag[SRC_G1];
  assign wake      = i0_wake | g0_wake | g1_wake;
endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk (
  input logic       clk,
  input logic       rst,
  input logic       int0_pin,
  input logic [1:0] int0_sense,
  input logic       int0_en,
  input logic       pcg0_en,
  input logic [2:0] flag_clr,
  input logic       io_clk_run,
  input logic       g0_hit,
  input logic       int0_flag,
  input logic       pcg0_flag,
  input logic       pcg1_flag,
  input logic       pcg0_req,
  input logic       pcg1_req,
  input logic       wake
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!int0_flag && !pcg0_flag && !pcg1_flag));

  p_req_after_en_r4: assert property (@(posedge clk) disable iff (rst)
    pcg0_req |-> $past(pcg0_en));

  p_req_has_flag_r4: assert property (@(posedge clk) disable iff (rst)
    pcg1_req |-> pcg1_flag);

  p_clear_works_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(flag_clr[1]) && !$past(g0_hit)) |-> !pcg0_flag);

  p_level_no_flag_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(int0_flag) |-> ($past(int0_sense) != 2'b00));

  p_edge_needs_clk_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(int0_flag) |-> $past(io_clk_run));

  p_level_wakes_r11: assert property (@(posedge clk) disable iff (rst)
    (int0_en && int0_sense == 2'b00 && !int0_pin) |-> wake);
endmodule

bind ext_irq_unit ext_irq_chk u_chk (
  .clk(clk), .rst(rst), .int0_pin(int0_pin), .int0_sense(int0_sense),
  .int0_en(int0_en), .pcg0_en(pcg0_en), .flag_clr(flag_clr),
  .io_clk_run(io_clk_run), .g0_hit(src_set[1]),
  .int0_flag(int0_flag), .pcg0_flag(pcg0_flag), .pcg1_flag(pcg1_flag),
  .pcg0_req(pcg0_req), .pcg1_req(pcg1_req), .wake(wake)
);

// File: tb/sim_ext_irq_unit.sv
`timescale 1ns/1ps
module sim_ext_irq_unit;
  logic        clk = 1'b0;
  logic        rst, int0_pin, int0_en, pcg0_en, pcg1_en, io_clk_run;
  logic [1:0]  int0_sense;
  logic [11:0] pc_pins;
  logic [7:0]  mask_g0;
  logic [3:0]  mask_g1;
  logic [2:0]  flag_clr, irq_ack;
  logic        int0_flag, pcg0_flag, pcg1_flag, int0_req, pcg0_req, pcg1_req, wake;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  ext_irq_unit u0 (
    .clk(clk), .rst(rst), .int0_pin(int0_pin), .int0_sense(int0_sense),
    .int0_en(int0_en), .pc_pins(pc_pins), .mask_g0(mask_g0), .mask_g1(mask_g1),
    .pcg0_en(pcg0_en), .pcg1_en(pcg1_en), .flag_clr(flag_clr), .irq_ack(irq_ack),
    .io_clk_run(io_clk_run), .int0_flag(int0_flag), .pcg0_flag(pcg0_flag),
    .pcg1_flag(pcg1_flag), .int0_req(int0_req), .pcg0_req(pcg0_req),
    .pcg1_req(pcg1_req), .wake(wake)
  );

  // {sense, int0_pin, pc_pins, expected {int0,g0,g1} flags}
  localparam int NV = 14;
  localparam logic [17:0] VEC [NV] = '{
    {2'b10, 1'b0, 12'h000, 3'b100},  // R6 falling
    {2'b10, 1'b1, 12'h000, 3'b000},  // R6 rising ignored
    {2'b11, 1'b0, 12'h000, 3'b000},  // R7 falling ignored
    {2'b11, 1'b1, 12'h000, 3'b100},  // R7 rising
    {2'b01, 1'b0, 12'h000, 3'b100},  // R8
    {2'b01, 1'b1, 12'h000, 3'b100},  // R8
    {2'b11, 1'b1, 12'h001, 3'b010},  // R2 enabled pin up
    {2'b11, 1'b1, 12'h000, 3'b010},  // R2 enabled pin down
    {2'b11, 1'b1, 12'h010, 3'b000},  // R2 masked pin
    {2'b11, 1'b1, 12'h000, 3'b000},  // R2 masked pin
    {2'b11, 1'b1, 12'h100, 3'b001},  // R3 pin 8
    {2'b11, 1'b1, 12'h200, 3'b001},  // R3 pin 8 down, 9 masked
    {2'b11, 1'b1, 12'h000, 3'b000},  // R3 masked pin 9
    {2'b11, 1'b1, 12'h401, 3'b011}   // R2 R3 both groups
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk) flag_clr = 3'b111;
    @(negedge clk) flag_clr = 3'b000;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; int0_pin = 1'b1; int0_sense = 2'b10; int0_en = 1'b1;
    pc_pins = '0; mask_g0 = 8'h0F; mask_g1 = 4'b0101;
    pcg0_en = 1'b1; pcg1_en = 1'b1; flag_clr = '0; irq_ack = '0; io_clk_run = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    wait_edges(3);
    chk("R1 flags", {1'b0, int0_flag, pcg0_flag, pcg1_flag}, 4'h0);
    chk("R1 reqs", {1'b0, int0_req, pcg0_req, pcg1_req}, 4'h0);

    for (int i = 0; i < NV; i++) begin
      int0_sense = VEC[i][17:16];
      int0_pin   = VEC[i][15];
      pc_pins    = VEC[i][14:3];
      wait_edges(3);
      chk($sformatf("R2/R3/R6-R8 vec%0d flags", i),
          {1'b0, int0_flag, pcg0_flag, pcg1_flag}, {1'b0, VEC[i][2:0]});
      chk($sformatf("R4 vec%0d reqs", i),
          {1'b0, int0_req, pcg0_req, pcg1_req}, {1'b0, VEC[i][2:0]});
      clear_all();
    end

    // known pin state
    pc_pins = '0;
    wait_edges(4);
    clear_all();

    // R12 latency
    pc_pins = 12'h002;
    wait_edges(2);
    chk("R12 before third edge", {3'b0, pcg0_flag}, 4'h0);
    wait_edges(1);
    chk("R12 at third edge", {3'b0, pcg0_flag}, 4'h1);
    clear_all();

    // R4 flag sets while disabled, request after enable
    pcg0_en = 1'b0;
    pc_pins = 12'h003;
    wait_edges(3);
    chk("R4 flag while disabled", {2'b0, pcg0_flag, pcg0_req}, 4'b0010);
    pcg0_en = 1'b1;
    wait_edges(1);
    chk("R4 req after enable", {3'b0, pcg0_req}, 4'h1);
    clear_all();

    // R5 acknowledge clears
    pc_pins = 12'h002;
    wait_edges(3);
    irq_ack = 3'b010;
    wait_edges(1);
    irq_ack = 3'b000;
    chk("R5 ack clears", {3'b0, pcg0_flag}, 4'h0);

    // R5 set wins over clear in same cycle
    pc_pins = 12'h003;
    repeat (2) @(posedge clk);
    @(negedge clk) flag_clr = 3'b010;
    @(negedge clk) flag_clr = 3'b000;
    chk("R5 set beats clear", {3'b0, pcg0_flag}, 4'h1);
    flag_clr = 3'b010;
    wait_edges(1);
    flag_clr = 3'b000;
    chk("R5 strobe clears", {3'b0, pcg0_flag}, 4'h0);

    // R9 level sense held low
    int0_sense = 2'b00;
    int0_pin = 1'b0;
    #1;
    chk("R11 level wake", {3'b0, wake}, 4'h1);
    wait_edges(3);
    chk("R9 level req", {2'b0, int0_req, int0_flag}, 4'b0010);
    wait_edges(10);
    chk("R9 level held", {2'b0, int0_req, int0_flag}, 4'b0010);
    int0_pin = 1'b1;
    wait_edges(3);
    chk("R9 level released", {3'b0, int0_req}, 4'h0);

    // R10 edges ignored with I/O clock stopped
    int0_sense = 2'b10;
    io_clk_run = 1'b0;
    int0_pin = 1'b0;
    wait_edges(4);
    chk("R10 falling ignored", {3'b0, int0_flag}, 4'h0);
    int0_pin = 1'b1;
    wait_edges(4);
    io_clk_run = 1'b1;
    wait_edges(1);

    // R11 pin-change wake with reference frozen
    io_clk_run = 1'b0;
    pc_pins = 12'h013;
    #1;
    chk("R11 masked no wake", {3'b0, wake}, 4'h0);
    pc_pins = 12'h012;
    #1;
    chk("R11 enabled wake", {3'b0, wake}, 4'h1);
    wait_edges(5);
    chk("R11 wake held", {3'b0, wake}, 4'h1);
    io_clk_run = 1'b1;
    wait_edges(1);
    chk("R11 wake drops", {3'b0, wake}, 4'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule